// File: doc/BRIEF.md
# Quadrature Position Counter with Modulo Wrap

This block turns the two phase outputs of an incremental shaft encoder into a position count. Each phase input first passes through a two-flop synchroniser and then through a glitch filter. The filtered pair is decoded: every legal Gray-code step becomes one up or one down count event. If both phases change at once, the step is illegal. It produces no count and instead sets a sticky error flag.

The count is kept at a selectable width of one, two, three or four bytes. In free-running mode it wraps at the top of that width. In modulo mode it wraps against a limit value held in a data register, so the count reads directly as angular position within one revolution. Each wrap raises a one-cycle carry pulse (upward) or borrow pulse (downward). A compare output shows when the count equals the limit.

The limit can be copied into the count in two ways: by a software strobe, or by the rising edge of a hardware load pin. A synchronous clear zeroes the count and the error flag. It overrides both load and counting.

Top module: `qenc_counter`

## Requirements
- R1: After reset the following hold: count is 0, the data register is 0, and carry, borrow and err_flag are 0. compare is therefore 1.
- R2: Phase states are written {phase_a, phase_b}. Each step along the order 00, 01, 11, 10, 00 adds one to the count. Each step along the reverse order subtracts one.
- R3: When both phases change in one filtered step, the count does not change and err_flag is set. err_flag stays set until clear.
- R4: A change on a phase input that lasts fewer than FILT_CYC clock cycles is ignored and does not alter the count.
- R5: width_sel values 0, 1, 2 and 3 select an active width of 8, 16, 24 and 32 bits. The count output shows only the active bits.
- R6: With mode_mod = 0, the count behaves as follows. Counting up from all-ones at the active width gives 0 and a one-cycle carry pulse. Counting down from 0 gives all-ones and a one-cycle borrow pulse.
- R7: With mode_mod = 1, the count behaves as follows. Counting up from the limit gives 0 and a carry pulse. Counting down from 0 gives the limit and a borrow pulse.
- R8: compare is 1 exactly when the count equals the data register at the active width.
- R9: A one-cycle load_sw copies the data register into the count on the next clock edge.
- R10: A rising edge on load_hw copies the data register into the count, after the input has been synchronised.
- R11: clear sets the count to 0 and clears err_flag on the next edge. It takes priority over load_sw, load_hw and count events in the same cycle.
- R12: A one-cycle limit_wr writes limit_in into the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| mode_mod | input | 1 | 1 selects modulo wrap against the limit, 0 selects free-running |
| width_sel | input | 2 | Active width: 0 for 8, 1 for 16, 2 for 24, 3 for 32 bits |
| limit_wr | input | 1 | Write strobe for the data register |
| limit_in | input | CNT_W | Value written to the data register |
| load_sw | input | 1 | Software strobe that loads the data register into the count |
| load_hw | input | 1 | Hardware load pin; its rising edge loads the count |
| clear | input | 1 | Synchronous clear of the count and err_flag |
| count | output | CNT_W | Position count at the active width |
| carry | output | 1 | One-cycle pulse on an upward wrap |
| borrow | output | 1 | One-cycle pulse on a downward wrap |
| compare | output | 1 | Count equals the data register |
| err_flag | output | 1 | Sticky flag for an illegal phase step |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, two synchroniser stages and a three-cycle filter. This lets every width_sel value be exercised, including wraps at 8 and 32 bits. A one-cycle glitch on a phase input stays shorter than the filter window, so it can be shown to be ignored. Every phase step is held for ten cycles, which is longer than the full synchroniser, filter, decoder and counter path. Each step can therefore be checked on its own. Random walks in both modes, each with a random width and limit, reach wraps at the limit and at zero many times.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_24 = 2'd2,
        WID_32 = 2'd3
    } width_e;

    // mask of the active bits for a width selection
    function automatic logic [31:0] width_mask(input width_e w);
        case (w)
            WID_8:   return 32'h0000_00FF;
            WID_16:  return 32'h0000_FFFF;
            WID_24:  return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // forward Gray step of the {a,b} phase pair
    function automatic logic [1:0] phase_fwd(input logic [1:0] s);
        case (s)
            2'b00:   return 2'b01;
            2'b01:   return 2'b11;
            2'b11:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/qenc_filter.sv
module qenc_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   filt;
        logic [CW-1:0]          run;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_in};
        if (st_q.sync[SYNC_STAGES-1] != st_q.filt) begin
            if (st_q.run == CW'(FILT_CYC - 1)) begin
                st_d.filt = st_q.sync[SYNC_STAGES-1];
                st_d.run  = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clean_out = st_q.filt;

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ph_in,
    output logic       ev_up,
    output logic       ev_dn,
    output logic       ev_err
);
    typedef struct packed {
        logic [1:0] prev;
        logic       up;
        logic       dn;
        logic       err;
    } dec_t;

    dec_t st_d, st_q;
    logic [1:0] diff;

    always_comb begin
        st_d      = st_q;
        st_d.up   = 1'b0;
        st_d.dn   = 1'b0;
        st_d.err  = 1'b0;
        st_d.prev = ph_in;
        diff      = ph_in ^ st_q.prev;
        if (diff == 2'b11) begin
            st_d.err = 1'b1;
        end else if (diff != 2'b00) begin
            if (ph_in == phase_fwd(st_q.prev)) st_d.up = 1'b1;
            else                               st_d.dn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_up  = st_q.up;
    assign ev_dn  = st_q.dn;
    assign ev_err = st_q.err;

endmodule

// File: rtl/qenc_core.sv
module qenc_core
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_up,
    input  logic             ev_dn,
    input  logic             ev_err,
    input  logic             hw_lvl,
    input  logic             mode_mod,
    input  logic [1:0]       width_sel,
    input  logic             limit_wr,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             load_sw,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             carry,
    output logic             borrow,
    output logic             compare,
    output logic             err_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             carry;
        logic             borrow;
        logic             err;
        logic             hw_prev;
    } core_t;

    core_t st_d, st_q;
    logic [31:0]      mask_full;
    logic [CNT_W-1:0] mask, cm, lm, top;
    logic             do_load;

    assign mask_full = width_mask(width_e'(width_sel));
    assign mask      = mask_full[CNT_W-1:0];
    assign cm        = st_q.cnt & mask;
    assign lm        = st_q.lim & mask;
    assign top       = mode_mod ? lm : mask;
    assign do_load   = load_sw || (hw_lvl && !st_q.hw_prev);

    always_comb begin
        st_d         = st_q;
        st_d.carry   = 1'b0;
        st_d.borrow  = 1'b0;
        st_d.hw_prev = hw_lvl;
        if (limit_wr) st_d.lim = limit_in;
        if (ev_err)   st_d.err = 1'b1;
        if (clear) begin
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end else if (do_load) begin
            st_d.cnt = lm;
        end else if (ev_up) begin
            if (cm >= top) begin
                st_d.cnt   = '0;
                st_d.carry = 1'b1;
            end else begin
                st_d.cnt = cm + 1'b1;
            end
        end else if (ev_dn) begin
            if (cm == '0 || cm > top) begin
                st_d.cnt    = top;
                st_d.borrow = 1'b1;
            end else begin
                st_d.cnt = cm - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = cm;
    assign compare  = (cm == lm);
    assign carry    = st_q.carry;
    assign borrow   = st_q.borrow;
    assign err_flag = st_q.err;

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
    parameter int CNT_BYTES   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3,
    localparam int CNT_W      = 8 * CNT_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             mode_mod,
    input  logic [1:0]       width_sel,
    input  logic             limit_wr,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             load_sw,
    input  logic             load_hw,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             carry,
    output logic             borrow,
    output logic             compare,
    output logic             err_flag
);
    logic [1:0] raw_ph, clean_ph;
    logic       hw_lvl;
    logic       ev_up, ev_dn, ev_err;

    assign raw_ph = {phase_a, phase_b};

    for (genvar i = 0; i < 2; i++) begin : g_phase
        qenc_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_in(raw_ph[i]), .clean_out(clean_ph[i])
        );
    end

    qenc_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(1)) u_hw_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(load_hw), .clean_out(hw_lvl)
    );

    qenc_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ph_in(clean_ph),
        .ev_up(ev_up), .ev_dn(ev_dn), .ev_err(ev_err)
    );

    qenc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .ev_up(ev_up), .ev_dn(ev_dn), .ev_err(ev_err), .hw_lvl(hw_lvl),
        .mode_mod(mode_mod), .width_sel(width_sel),
        .limit_wr(limit_wr), .limit_in(limit_in),
        .load_sw(load_sw), .clear(clear),
        .count(count), .carry(carry), .borrow(borrow),
        .compare(compare), .err_flag(err_flag)
    );

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_mod,
    input logic [1:0]       width_sel,
    input logic             clear,
    input logic [CNT_W-1:0] count,
    input logic             carry,
    input logic             borrow,
    input logic             err_flag
);
    logic [31:0] act_bits;
    always_comb begin
        act_bits = 32'hFFFF_FFFF >> (8 * (3 - int'(width_sel)));
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0) && !err_flag)                               // R11
        else $error("clear did not zero the count");

    AST_CARRY_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (count == '0))                                            // R6
        else $error("carry without zero count");

    AST_BORROW_TO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (borrow && !mode_mod && $past(!mode_mod) && $stable(width_sel))
        |-> (count == act_bits[CNT_W-1:0]))                                 // R6
        else $error("free borrow did not land on all-ones");

    AST_WRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry && borrow))                                                 // R7
        else $error("carry and borrow together");

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clear) |=> err_flag)                                  // R3
        else $error("error flag dropped without clear");

endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_mod(mode_mod), .width_sel(width_sel),
    .clear(clear), .count(count), .carry(carry), .borrow(borrow),
    .err_flag(err_flag)
);

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb;
    localparam int W    = 32;
    localparam int HOLD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         phase_a = 1'b0, phase_b = 1'b0;
    logic         mode_mod = 1'b0;
    logic [1:0]   width_sel = 2'd0;
    logic         limit_wr = 1'b0;
    logic [W-1:0] limit_in = '0;
    logic         load_sw = 1'b0, load_hw = 1'b0, clear = 1'b0;
    logic [W-1:0] count;
    logic         carry, borrow, compare, err_flag;

    int n_chk = 0, n_fail = 0;
    int carry_seen = 0, borrow_seen = 0;
    int carry_exp = 0, borrow_exp = 0;
    logic [1:0]   ph = 2'b00;
    logic [W-1:0] e_cnt = '0, e_lim = '0;

    always #4 clk = ~clk;

    qenc_counter u_dut (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .mode_mod(mode_mod), .width_sel(width_sel), .limit_wr(limit_wr),
        .limit_in(limit_in), .load_sw(load_sw), .load_hw(load_hw),
        .clear(clear), .count(count), .carry(carry), .borrow(borrow),
        .compare(compare), .err_flag(err_flag)
    );

    always @(posedge clk) begin
        if (carry)  carry_seen++;
        if (borrow) borrow_seen++;
    end

    function automatic logic [W-1:0] msk(input logic [1:0] w);
        return 32'hFFFF_FFFF >> (8 * (3 - int'(w)));
    endfunction

    function automatic logic [1:0] fwd(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] rev(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // one legal encoder step, model updated, then count and pulses checked
    task automatic step(input bit up, input string req);
        logic [W-1:0] m, top;
        m   = msk(width_sel);
        top = mode_mod ? (e_lim & m) : m;
        ph  = up ? fwd(ph) : rev(ph);
        {phase_a, phase_b} = ph;
        if (up) begin
            if (e_cnt >= top) begin e_cnt = '0; carry_exp++; end
            else e_cnt = e_cnt + 1;
        end else begin
            if (e_cnt == '0) begin e_cnt = top; borrow_exp++; end
            else e_cnt = e_cnt - 1;
        end
        settle(HOLD);
        chk(req, count, e_cnt);
        chk({req, " carry"}, W'(carry_seen), W'(carry_exp));
        chk({req, " borrow"}, W'(borrow_seen), W'(borrow_exp));
    endtask

    task automatic pulse_clear();
        clear = 1'b1; settle(1); clear = 1'b0; settle(1);
        e_cnt = '0;
    endtask

    task automatic write_lim(input logic [W-1:0] v);
        limit_in = v; limit_wr = 1'b1; settle(1); limit_wr = 1'b0; settle(1);
        e_lim = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        settle(3);
        // R1 reset state
        chk("R1 count", count, '0);
        chk("R1 flags", W'({carry, borrow, err_flag}), '0);
        chk("R1 compare", W'(compare), 1);
        rst_n = 1'b1;
        settle(2);

        // R2 / R5 / R6 at 8 bits, free-running
        for (int i = 0; i < 4; i++) step(1'b1, "R2 up");
        for (int i = 0; i < 6; i++) step(1'b0, "R6 down wrap");
        chk("R5 8-bit top", count, 32'hFE);
        step(1'b1, "R2 up"); step(1'b1, "R6 up wrap");

        // R4 glitch shorter than filter
        phase_a = ~ph[1]; settle(1); phase_a = ph[1]; settle(HOLD);
        chk("R4 glitch ignored", count, e_cnt);

        // R3 illegal step
        ph = ~ph; {phase_a, phase_b} = ph; settle(HOLD);
        chk("R3 no count", count, e_cnt);
        chk("R3 err set", W'(err_flag), 1);
        step(1'b1, "R3 sticky"); chk("R3 err kept", W'(err_flag), 1);

        // R12 / R8 / R9
        write_lim(32'h0A);
        chk("R8 compare low", W'(compare), W'(count == 32'h0A));
        load_sw = 1'b1; settle(1); load_sw = 1'b0; e_cnt = 32'h0A;
        chk("R9 load_sw", count, 32'h0A);
        chk("R8 compare high", W'(compare), 1);

        // R11 clear wins over load, clears err
        clear = 1'b1; load_sw = 1'b1; settle(1); clear = 1'b0; load_sw = 1'b0;
        e_cnt = '0;
        chk("R11 clear priority", count, '0);
        chk("R11 err cleared", W'(err_flag), 0);

        // R7 modulo at 16 bits
        mode_mod = 1'b1; width_sel = 2'd1; settle(1);
        step(1'b0, "R7 down to limit");
        chk("R7 at limit", count, 32'h0A);
        step(1'b1, "R7 up to zero");

        // R10 hardware load
        pulse_clear();
        load_hw = 1'b1; settle(6); load_hw = 1'b0; settle(2);
        e_cnt = 32'h0A;
        chk("R10 load_hw", count, 32'h0A);

        // R5 / R6 at 32 and 24 bits
        mode_mod = 1'b0; width_sel = 2'd3;
        write_lim(32'hFFFF_FFFE);
        load_sw = 1'b1; settle(1); load_sw = 1'b0; e_cnt = 32'hFFFF_FFFE;
        step(1'b1, "R5 32-bit up");
        step(1'b1, "R6 32-bit wrap");
        width_sel = 2'd2; pulse_clear();
        step(1'b0, "R5 24-bit borrow");
        chk("R5 24-bit top", count, 32'h00FF_FFFF);

        // random walks
        for (int seg = 0; seg < 8; seg++) begin
            width_sel = 2'($urandom_range(0, 3));
            mode_mod  = 1'($urandom_range(0, 1));
            write_lim(W'($urandom_range(1, 40)));
            pulse_clear();
            for (int k = 0; k < 40; k++)
                step(1'($urandom_range(0, 1)), mode_mod ? "R7 random" : "R2 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule